// File: doc/BRIEF.md
# Serial 1-1-0 Pattern Detector

This block watches a single serial bit stream, sampled on each rising clock edge, and raises a one-cycle flag once the three most recent samples, oldest first, were 1, 1 and 0. It is a four-state Moore machine. The flag is decoded from the state register alone, so it carries no combinational path from the data input. Matches may share bits with earlier ones, and a run of ones of any length followed by a zero counts as one match.

The state is held in two flip-flops with a fixed, hand-chosen code. One bit always stores the most recent sample. The other bit marks either a run of at least two ones or a completed match. Reset is active low and asynchronous, and it returns the machine to the all-zero code, which means "no one seen yet". The data input is assumed to be synchronous to the clock already.

Top module: `seq110_moore`

## Requirements
- R1: While `rst_n` is low, `hit` is 0 at once, without waiting for a clock edge, and the sample history is cleared.
- R2: After the rising edge that samples a 0, `hit` is 1 if the two samples before that 0 were both 1 and all three samples came after reset release. At every other edge `hit` is 0.
- R3: `hit` is never high in two consecutive cycles.
- R4: `hit` depends only on the registered state, so changing `din` between clock edges leaves `hit` unchanged.
- R5: Matches may overlap with earlier input. The stream 1,1,0,1,1,0 gives two one-cycle pulses, one after each 0.
- R6: A run of any length of ones (two or more) followed by a 0 gives exactly one pulse, after the 0.
- R7: Samples taken before a reset never count toward a match. The stream 1,1, then reset, then 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data bit, sampled on each rising edge |
| hit | output | 1 | High for one cycle after 1,1,0 has been sampled |

## Verification
Each sample lands in the state register on its rising edge, so `hit` answers for that sample in the same clock period, after that edge, and holds until the next edge. The bench changes `din` on the falling edge. It reads `hit` a few nanoseconds after each rising edge and compares it with a three-bit reference history updated at that edge. Reset effects are checked right after `rst_n` falls, with no clock edge in between. The check for R4 toggles `din` after that read and reads `hit` again before the next edge.

// File: rtl/seq110_pkg.sv
package seq110_pkg;

    // Two-bit state code. The low bit always holds the most recent sample.
    // The high bit is set in the "two or more ones" and "match" states.
    //   idle  = 00, one   = 01, ones  = 11, match = 10
    localparam int STATE_W = 2;

    typedef struct packed {
        logic run;   // high bit: run of ones seen, or match just completed
        logic last;  // low bit: the previous sampled input
    } det_state_t;

    localparam det_state_t ST_IDLE  = '{run: 1'b0, last: 1'b0};
    localparam det_state_t ST_ONE   = '{run: 1'b0, last: 1'b1};
    localparam det_state_t ST_ONES  = '{run: 1'b1, last: 1'b1};
    localparam det_state_t ST_MATCH = '{run: 1'b1, last: 1'b0};

endpackage

// File: rtl/seq110_next.sv
module seq110_next
    import seq110_pkg::*;
(
    input  det_state_t cur,
    input  logic       din,
    output det_state_t nxt
);
    always_comb begin
        // The low bit copies the input, so it is the last sample after the edge.
        nxt.last = din;
        // The high bit is set after a second consecutive one,
        // or on a zero that ends a run of ones.
        nxt.run  = (cur.run & cur.last) | (cur.last & din);
    end
endmodule

// File: rtl/seq110_decode.sv
module seq110_decode
    import seq110_pkg::*;
(
    input  det_state_t cur,
    output logic       hit
);
    // The output is active only in the match state (code 10).
    always_comb begin
        hit = cur.run & ~cur.last;
    end
endmodule

// File: rtl/seq110_moore.sv
module seq110_moore
    import seq110_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    det_state_t state_q;
    det_state_t state_d;
    det_state_t nxt_w;
    logic       hit_w;

    seq110_next u_next (
        .cur (state_q),
        .din (din),
        .nxt (nxt_w)
    );

    seq110_decode u_decode (
        .cur (state_q),
        .hit (hit_w)
    );

    always_comb begin
        state_d = nxt_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit = hit_w;
endmodule

// File: rtl/seq110_moore_chk.sv
module seq110_moore_chk (
    input logic clk,
    input logic rst_n,
    input logic din,
    input logic hit
);
    // Counts the rising edges since reset release, saturating at 3.
    logic [1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 2'd0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !hit);

    // R2
    pattern_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3) |-> (hit == (!$past(din) && $past(din, 2) && $past(din, 3))));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R7
    young_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 2'd3) |-> !hit);

    // R6
    rise_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> !$past(din));
endmodule

bind seq110_moore seq110_moore_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .hit   (hit)
);

// File: tb/seq110_moore_test.sv
`timescale 1ns/1ps
module seq110_moore_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic hit;

    int checks = 0;
    int errors = 0;
    logic [2:0] hist = 3'b000;  // bit 2 oldest, bit 0 newest
    int cnt = 0;                // samples since reset release
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    seq110_moore uut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .hit   (hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hit=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic ref_hit();
        return (cnt >= 3) && (hist == 3'b110);
    endfunction

    task automatic step(input logic b, input string req);
        @(negedge clk);
        din = b;
        @(posedge clk);
        hist = {hist[1:0], b};
        cnt++;
        #5;
        check(req, hit, ref_hit());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        #2;
        check("R1", hit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        hist = 3'b000;
        cnt = 0;
    endtask

    initial begin
        #1;
        check("R1 reset state", hit, 1'b0);
        @(posedge clk);
        #5;
        check("R1 reset held", hit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every six-bit stream after a fresh reset
        for (int s = 0; s < 64; s++) begin
            do_reset();
            for (int i = 5; i >= 0; i--) begin
                step(s[i], "R2");
            end
        end

        // R5: overlapping matches give two pulses
        do_reset();
        step(1'b1, "R5"); step(1'b1, "R5"); step(1'b0, "R5");
        check("R5 first pulse", hit, 1'b1);
        step(1'b1, "R5"); step(1'b1, "R5"); step(1'b0, "R5");
        check("R5 second pulse", hit, 1'b1);
        step(1'b0, "R3");

        // R6: long run of ones then a zero
        do_reset();
        for (int k = 0; k < 20; k++) begin
            step(1'b1, "R6");
            check("R6 no pulse in run", hit, 1'b0);
        end
        step(1'b0, "R6");
        check("R6 pulse", hit, 1'b1);
        step(1'b0, "R3");
        check("R3 pulse ends", hit, 1'b0);

        // R4: toggling din between edges does not move hit
        do_reset();
        step(1'b1, "R4"); step(1'b1, "R4"); step(1'b0, "R4");
        din = 1'b1;
        #2;
        check("R4 hit held with din=1", hit, 1'b1);
        din = 1'b0;
        #1;
        check("R4 hit held with din=0", hit, 1'b1);
        step(1'b1, "R4");
        din = 1'b0;
        #2;
        check("R4 no pulse with din=0", hit, 1'b0);

        // R1: asynchronous reset clears a pulse mid-cycle
        do_reset();
        step(1'b1, "R1"); step(1'b1, "R1"); step(1'b0, "R1");
        rst_n = 1'b0;
        #1;
        check("R1 async clear", hit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        hist = 3'b000;
        cnt = 0;

        // R7: samples before reset do not count
        do_reset();
        step(1'b1, "R7"); step(1'b1, "R7");
        do_reset();
        step(1'b0, "R7");
        check("R7 no pulse after reset", hit, 1'b0);
        step(1'b1, "R7"); step(1'b1, "R7"); step(1'b0, "R7");
        check("R7 later match", hit, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule